// File: doc/BRIEF.md
# Short-Instruction Effective Address Unit

This block turns a 12-bit instruction into the value that its execution stage needs. The instruction has a 6-bit function code in its upper half and a 6-bit field, called E here, in its lower half. A separate 3-bit mode input, supplied by the instruction decoder, says how E is to be interpreted. E can be a zero-extended immediate operand, a direct address in the first 64 words of storage, a pointer into those 64 words, or a signed-direction offset from the program counter. A further mode fetches a jump target through a pointer located at the program counter plus E.

A one-cycle `start` accepts an instruction, together with the program counter value it is relative to. Modes that need no memory access finish one clock later with a `done` pulse. The two pointer modes issue a single read on a synchronous memory port and hold `busy` high while it is in flight. They finish three clocks after `start`, with the fetched word as the address. The function code is captured when an instruction is accepted and kept until the next accepted instruction.

Top module: `ea_unit`

## Requirements
- R1: While and directly after reset, `done`, `busy`, `mem_rd_en`, `addr_valid` and `is_immediate` are 0, and `addr` and `imm_operand` are 0.
- R2: Mode 0 (immediate): one clock after `start`, `done`=1, `is_immediate`=1, `addr_valid`=0, `imm_operand` = E zero-extended to 12 bits.
- R3: Mode 1 (direct): one clock after `start`, `done`=1, `addr_valid`=1, `is_immediate`=0, `addr` = E zero-extended (a location 0 to 63).
- R4: Mode 2 (pointer): one clock after `start`, `mem_rd_en`=1 with `mem_rd_addr` = E zero-extended and `busy`=1. The word returned one clock after the read is presented as `addr`, with `addr_valid`=1 and `done`=1, three clocks after `start`.
- R5: Mode 3 (forward relative): `addr` = (`pc` + E) mod 4096 one clock after `start`, with `addr_valid`=1.
- R6: Mode 4 (backward relative): `addr` = (`pc` − E) mod 4096 one clock after `start`, with `addr_valid`=1.
- R7: Mode 5 (relative-pointer jump): the read address is (`pc` + E) mod 4096, and `addr` is the word read from there, with the same timing as R4.
- R8: `func_code` equals instruction bits [11:6] from the clock after an accepted `start`, and holds until the next accepted `start`.
- R9: `start` while `busy` is 1 is ignored: `func_code`, the pending result and the count of `done` pulses are unchanged.
- R10: `done` lasts exactly one clock per accepted instruction, and `mem_rd_en` lasts exactly one clock per pointer mode.
- R11: Mode codes 6 and 7 complete in one clock with `done`=1, `addr_valid`=0 and `is_immediate`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Accept the instruction on `instr`/`mode`/`pc` |
| instr | input | 12 | Instruction: function code [11:6], E [5:0] |
| mode | input | 3 | Addressing mode code (0..5 used) |
| pc | input | 12 | Program counter value for relative modes |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | 12 | Memory read address |
| mem_rd_data | input | 12 | Read data, valid one clock after the strobe |
| busy | output | 1 | A pointer read is in progress |
| func_code | output | 6 | Latched function code |
| addr | output | 12 | Effective operand or jump address |
| addr_valid | output | 1 | `addr` holds a valid address |
| imm_operand | output | 12 | Zero-extended immediate operand |
| is_immediate | output | 1 | `imm_operand` is valid |
| done | output | 1 | One-clock completion pulse |

## Verification
A controller stuck in its read or wait state shows at the ports as `busy` staying high and a missing `done`. This becomes visible within three clocks of `start`, and the next direct instruction is then also dropped. A wrong mode selection or a carry error in the relative adder shows on `addr` in the very clock of `done`. The wrap cases near address 0 and 4095 expose a truncation fault. A lost capture of the function code shows on `func_code` one clock after `start`.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int WORD_W = 12;
  localparam int FUNC_W = 6;
  localparam int E_W    = 6;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MD_IMM    = 3'd0,
    MD_DIR    = 3'd1,
    MD_IND    = 3'd2,
    MD_RELF   = 3'd3,
    MD_RELB   = 3'd4,
    MD_RELIND = 3'd5
  } ea_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_WAIT = 2'd2
  } ea_state_e;
endpackage

// File: rtl/ea_addr_calc.sv
module ea_addr_calc
  import ea_pkg::*;
#(
  parameter int AW  = WORD_W,
  parameter int EW  = E_W,
  parameter int MW  = MODE_W
) (
  input  logic [MW-1:0] mode,
  input  logic [EW-1:0] e_field,
  input  logic [AW-1:0] pc,
  output logic [AW-1:0] target,
  output logic          need_read,
  output logic          is_imm,
  output logic          has_addr
);
  localparam int PAD_W = AW - EW;

  logic [AW-1:0] e_ext;
  logic [AW-1:0] pc_fwd;
  logic [AW-1:0] pc_bwd;

  assign e_ext  = {{PAD_W{1'b0}}, e_field};
  assign pc_fwd = pc + e_ext;
  assign pc_bwd = pc - e_ext;

  always_comb begin
    target    = '0;
    need_read = 1'b0;
    is_imm    = 1'b0;
    has_addr  = 1'b0;
    case (mode)
      MD_IMM:    begin target = e_ext;  is_imm    = 1'b1; end
      MD_DIR:    begin target = e_ext;  has_addr  = 1'b1; end
      MD_IND:    begin target = e_ext;  need_read = 1'b1; end
      MD_RELF:   begin target = pc_fwd; has_addr  = 1'b1; end
      MD_RELB:   begin target = pc_bwd; has_addr  = 1'b1; end
      MD_RELIND: begin target = pc_fwd; need_read = 1'b1; end
      default:   target = '0;
    endcase
  end

  always_comb begin
    assert (!(need_read && is_imm)) else $error("AST_ONE_KIND"); // R2
  end
endmodule

// File: rtl/ea_ctrl.sv
module ea_ctrl
  import ea_pkg::*;
#(
  parameter int AW = WORD_W,
  parameter int FW = FUNC_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [FW-1:0] func_in,
  input  logic [AW-1:0] target,
  input  logic          need_read,
  input  logic          is_imm,
  input  logic          has_addr,
  input  logic [AW-1:0] mem_rd_data,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_rd_addr,
  output logic          busy,
  output logic [FW-1:0] func_code,
  output logic [AW-1:0] addr,
  output logic          addr_valid,
  output logic [AW-1:0] imm_operand,
  output logic          is_immediate,
  output logic          done
);
  ea_state_e state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      mem_rd_en    <= 1'b0;
      mem_rd_addr  <= '0;
      busy         <= 1'b0;
      func_code    <= '0;
      addr         <= '0;
      addr_valid   <= 1'b0;
      imm_operand  <= '0;
      is_immediate <= 1'b0;
      done         <= 1'b0;
    end else begin
      done      <= 1'b0;
      mem_rd_en <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            func_code <= func_in;
            if (need_read) begin
              mem_rd_en    <= 1'b1;
              mem_rd_addr  <= target;
              busy         <= 1'b1;
              addr_valid   <= 1'b0;
              is_immediate <= 1'b0;
              state        <= ST_READ;
            end else begin
              done         <= 1'b1;
              addr         <= has_addr ? target : '0;
              addr_valid   <= has_addr;
              imm_operand  <= is_imm ? target : '0;
              is_immediate <= is_imm;
            end
          end
        end
        ST_READ: state <= ST_WAIT;
        ST_WAIT: begin
          addr         <= mem_rd_data;
          addr_valid   <= 1'b1;
          imm_operand  <= '0;
          is_immediate <= 1'b0;
          done         <= 1'b1;
          busy         <= 1'b0;
          state        <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10
  AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> !mem_rd_en); // R10
  AST_READ_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> busy); // R4
  AST_READ_THEN_DONE: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> ##1 done); // R4
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R4
  AST_RESULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(addr_valid && is_immediate)); // R2
  AST_FUNC_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(func_code)); // R9
endmodule

// File: rtl/ea_unit.sv
module ea_unit
  import ea_pkg::*;
#(
  parameter int AW = WORD_W,
  parameter int FW = FUNC_W,
  parameter int EW = E_W,
  parameter int MW = MODE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] instr,
  input  logic [MW-1:0] mode,
  input  logic [AW-1:0] pc,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_rd_addr,
  input  logic [AW-1:0] mem_rd_data,
  output logic          busy,
  output logic [FW-1:0] func_code,
  output logic [AW-1:0] addr,
  output logic          addr_valid,
  output logic [AW-1:0] imm_operand,
  output logic          is_immediate,
  output logic          done
);
  logic [AW-1:0] target;
  logic          need_read;
  logic          is_imm;
  logic          has_addr;

  ea_addr_calc #(.AW(AW), .EW(EW), .MW(MW)) u_calc (
    .mode      (mode),
    .e_field   (instr[EW-1:0]),
    .pc        (pc),
    .target    (target),
    .need_read (need_read),
    .is_imm    (is_imm),
    .has_addr  (has_addr)
  );

  ea_ctrl #(.AW(AW), .FW(FW)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .func_in      (instr[AW-1:AW-FW]),
    .target       (target),
    .need_read    (need_read),
    .is_imm       (is_imm),
    .has_addr     (has_addr),
    .mem_rd_data  (mem_rd_data),
    .mem_rd_en    (mem_rd_en),
    .mem_rd_addr  (mem_rd_addr),
    .busy         (busy),
    .func_code    (func_code),
    .addr         (addr),
    .addr_valid   (addr_valid),
    .imm_operand  (imm_operand),
    .is_immediate (is_immediate),
    .done         (done)
  );
endmodule

// File: tb/tb_ea_unit.sv
module tb_ea_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [11:0] instr = '0;
  logic [2:0]  mode = '0;
  logic [11:0] pc = '0;
  logic        mem_rd_en;
  logic [11:0] mem_rd_addr;
  logic [11:0] mem_rd_data = '0;
  logic        busy;
  logic [5:0]  func_code;
  logic [11:0] addr;
  logic        addr_valid;
  logic [11:0] imm_operand;
  logic        is_immediate;
  logic        done;

  int n_checks = 0;
  int n_fails  = 0;

  localparam logic [11:0] SCRAMBLE = 12'hA5C;

  always #4 clk = ~clk;

  always_ff @(posedge clk)
    if (mem_rd_en) mem_rd_data <= mem_rd_addr ^ SCRAMBLE;

  ea_unit dut (
    .clk(clk), .rst(rst), .start(start), .instr(instr), .mode(mode), .pc(pc),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .busy(busy), .func_code(func_code), .addr(addr), .addr_valid(addr_valid),
    .imm_operand(imm_operand), .is_immediate(is_immediate), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input logic [11:0] act,
                     input logic [11:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [11:0] ins, input logic [2:0] md,
                       input logic [11:0] p);
    @(negedge clk);
    start = 1'b1; instr = ins; mode = md; pc = p;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_plain(input logic [11:0] ins, input logic [2:0] md,
                           input logic [11:0] p, input logic [11:0] exp_addr,
                           input bit exp_av, input logic [11:0] exp_imm,
                           input bit exp_isimm, input string tag);
    issue(ins, md, p);
    chk(done === 1'b1, {tag, " done"}, {11'b0, done}, 12'd1);
    chk(addr === exp_addr, {tag, " addr"}, addr, exp_addr);
    chk(addr_valid === exp_av, {tag, " addr_valid"}, {11'b0, addr_valid}, {11'b0, exp_av});
    chk(imm_operand === exp_imm, {tag, " imm"}, imm_operand, exp_imm);
    chk(is_immediate === exp_isimm, {tag, " is_imm"}, {11'b0, is_immediate}, {11'b0, exp_isimm});
    chk(func_code === ins[11:6], {tag, " R8 func"}, {6'b0, func_code}, {6'b0, ins[11:6]});
    @(negedge clk);
    chk(done === 1'b0, {tag, " R10 done pulse"}, {11'b0, done}, 12'd0);
  endtask

  task automatic run_ptr(input logic [11:0] ins, input logic [2:0] md,
                         input logic [11:0] p, input logic [11:0] exp_ptr,
                         input bit poke, input string tag);
    issue(ins, md, p);
    chk(mem_rd_en === 1'b1 && busy === 1'b1, {tag, " rd_en/busy"},
        {10'b0, mem_rd_en, busy}, 12'd3);
    chk(mem_rd_addr === exp_ptr, {tag, " rd_addr"}, mem_rd_addr, exp_ptr);
    if (poke) begin
      start = 1'b1; instr = 12'hFFF; mode = 3'd1;
    end
    @(negedge clk);
    start = 1'b0;
    chk(mem_rd_en === 1'b0 && done === 1'b0, {tag, " R10 rd pulse"},
        {10'b0, mem_rd_en, done}, 12'd0);
    @(negedge clk);
    chk(done === 1'b1 && busy === 1'b0, {tag, " done"}, {10'b0, done, busy}, 12'd2);
    chk(addr === (exp_ptr ^ SCRAMBLE) && addr_valid === 1'b1, {tag, " addr"},
        addr, exp_ptr ^ SCRAMBLE);
    chk(func_code === ins[11:6], {tag, " R8 R9 func"}, {6'b0, func_code}, {6'b0, ins[11:6]});
    @(negedge clk);
    chk(done === 1'b0, {tag, " R9 R10 no extra done"}, {11'b0, done}, 12'd0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(done === 0 && busy === 0 && mem_rd_en === 0 && addr_valid === 0 &&
        is_immediate === 0, "R1 flags", {7'b0, done, busy, mem_rd_en, addr_valid,
        is_immediate}, 12'd0);
    chk(addr === 0 && imm_operand === 0, "R1 values", addr | imm_operand, 12'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_reset();
    run_plain(12'b010101_111111, 3'd0, 12'h123, 12'h000, 1'b0, 12'h03F, 1'b1, "R2 imm");
    run_plain(12'b000001_000000, 3'd0, 12'h000, 12'h000, 1'b0, 12'h000, 1'b1, "R2 imm0");
    run_plain(12'b110000_101010, 3'd1, 12'h800, 12'h02A, 1'b1, 12'h000, 1'b0, "R3 dir");
    run_plain(12'b001100_000101, 3'd3, 12'h100, 12'h105, 1'b1, 12'h000, 1'b0, "R5 fwd");
    run_plain(12'b001100_000101, 3'd3, 12'hFFE, 12'h003, 1'b1, 12'h000, 1'b0, "R5 fwd wrap");
    run_plain(12'b011100_001010, 3'd4, 12'h100, 12'h0F6, 1'b1, 12'h000, 1'b0, "R6 back");
    run_plain(12'b011100_001010, 3'd4, 12'h002, 12'hFF8, 1'b1, 12'h000, 1'b0, "R6 back wrap");
    run_plain(12'b111000_000011, 3'd6, 12'h040, 12'h000, 1'b0, 12'h000, 1'b0, "R11 mode6");
    run_plain(12'b111001_000011, 3'd7, 12'h040, 12'h000, 1'b0, 12'h000, 1'b0, "R11 mode7");
    run_ptr(12'b100010_011001, 3'd2, 12'h777, 12'h019, 1'b0, "R4 ptr");
    run_ptr(12'b100110_111111, 3'd5, 12'hFF0, 12'h02F, 1'b0, "R7 relptr wrap");
    run_ptr(12'b101010_000111, 3'd2, 12'h000, 12'h007, 1'b1, "R9 ignore");
    run_plain(12'b000111_000001, 3'd1, 12'h000, 12'h001, 1'b1, 12'h000, 1'b0, "R8 after ptr");
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog actual=%h expected=%h", 12'd1, 12'd0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule